// File: doc/BRIEF.md
# Multiplexed-Address Asynchronous DRAM Controller

This block lets synchronous logic reach a classic asynchronous dynamic RAM of 256K bytes. The memory has nine shared address pins, an eight-bit data path and four active-low strobes. Clients hand it one byte-wide read or write at a time over a valid/ready handshake. The controller splits the 18-bit address into a row half and a column half. It puts the row half on the pins before the row strobe falls, then switches the pins to the column half before the column strobe falls. It holds every strobe and the data bus for as many clock cycles as the memory's nanosecond limits require. It returns one response pulse per access.

The memory forgets its contents unless every row is opened again within 8 ms. A scheduler therefore raises a refresh request at a fixed interval. The sequencer serves it as a row-strobe-only cycle on the next row in turn, and only between client accesses. The data path is split into an output value, an output enable and an input value, so the pad ring can build the shared bidirectional pins.

All limits are given in nanoseconds and converted to clock cycles by rounding up at the configured clock period. The defaults are a 10 ns clock and a 110/60/15/35 ns row-cycle / row-to-data / column-to-data / column-cycle set.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all four strobes are high, the data bus is not driven, no response is signalled and `req_ready` is high.
- R2: The request address is split with row = `req_addr[17:9]` and column = `req_addr[8:0]`. The row value is on `dram_a` in the cycle before the row strobe falls and stays unchanged as it falls. The column value is on `dram_a` when the column strobe falls.
- R3: The column strobe falls exactly 2 cycles after the row strobe falls, and it is low only while the row strobe is low.
- R4: A write lowers `dram_we_n` and drives `dram_dq_out` with `dram_dq_oe` at least one cycle before the column strobe falls. `dram_oe_n` stays high throughout the write.
- R5: A read lowers `dram_oe_n` with `dram_we_n` high and the bus released. It captures `dram_dq_in` only after at least ceil(60 ns) cycles from the row strobe fall and at least ceil(15 ns) cycles from the column strobe fall.
- R6: `dram_we_n` and `dram_oe_n` are never low together, and `dram_dq_oe` is high only while `dram_we_n` is low and `dram_oe_n` is high.
- R7: Two row-strobe falls are at least max(ceil(110 ns), ceil(35 ns)) cycles apart. Two column-strobe falls are at least ceil(35 ns) cycles apart.
- R8: `rsp_valid` is a one-cycle pulse. It comes max(RAC, 2+CAC)+2 cycles after the accepting clock edge, in request order. For a read, `rsp_rdata` carries the byte last written to that address.
- R9: Refresh is a row-strobe-only cycle with no column strobe. The refreshed rows start at 0 and ascend with wrap-around at 511. Refreshes come once every floor(8 ms / (clock period x 512)) cycles, each deferred by at most one access.
- R10: A refresh is only started between accesses. `req_ready` is low whenever the row strobe is low, and a continuous request stream does not starve refresh.
- R11: Each nanosecond limit becomes a cycle count by rounding up. Under back-to-back requests, row accesses repeat at exactly the row-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address, row in upper half |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Access complete pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid on reads |
| dram_a | output | 9 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for the data pins |
| dram_dq_in | input | 8 | Data from memory |

## Verification
The bench's memory model returns garbage until both the row-to-data and column-to-data limits have passed. A controller that captures one cycle early therefore returns a wrong byte, and the response-latency comparison also catches it. Corner addresses (all-zero, all-ones, maximum row with column zero, maximum column with row zero) and an ordered queue of expected row/column pairs expose a swapped or mis-split address. Back-to-back request streams press the row-cycle gap, so a controller that gates the next access one cycle too soon fails the gap check. A long stream and idle stretches test that refresh rows step in order, keep their interval and are never starved or inserted mid-access.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    // Sequencer phase of one memory cycle
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETUP  = 2'd1,
        SEQ_ACTIVE = 2'd2
    } seq_state_e;

    // Round a nanosecond limit up to whole clock cycles
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_phase_cnt.sv
// Counts cycles since the last row strobe fall.
// Restart loads zero; otherwise it counts up and saturates at all ones.
// Reset leaves it saturated, so the first access is never held back.
module dram_phase_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Saturating phase count, zeroed at each row strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= CNT_MAX;
        else if (restart)      count <= '0;
        else if (count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Raises a refresh request every INTERVAL cycles and holds it until
// the sequencer grants it. It also keeps the row to refresh next,
// which starts at zero and wraps after the last row.
// Assumes a grant never lags by more than one interval.
module dram_refresh_sched #(
    parameter int ROW_W    = 9,
    parameter int INTERVAL = 1562
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int TMR_W = $clog2(INTERVAL + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(INTERVAL - 1);

    logic [TMR_W-1:0] tmr;
    logic             tick;

    // Interval tick on the last count
    always_comb tick = (tmr == TMR_LAST);

    // Free-running interval timer
    always_ff @(posedge clk) begin
        if (!rst_n)    tmr <= '0;
        else if (tick) tmr <= '0;
        else           tmr <= tmr + 1'b1;
    end

    // Pending flag: set by tick, cleared by grant
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (tick)  pending <= 1'b1;
        else if (grant) pending <= 1'b0;
    end

    // Next-row pointer, advanced on each granted refresh
    always_ff @(posedge clk) begin
        if (!rst_n)     row <= '0;
        else if (grant) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_seq.sv
// Access sequencer. Every pin output is registered.
// Timeline, with phase 0 being the first cycle of a low row strobe:
//   setup cycle : row (or refresh row) on the pins, strobes high
//   phase 0 end : column on the pins; write enable + data, or output enable
//   phase RCD-1 : column strobe falls (not for refresh)
//   phase KD    : all strobes rise, read byte captured, response pulsed
// A new row strobe fall waits until GAP cycles after the previous one.
// Assumes RCD_CYC >= 2 and KD_CYC >= RCD_CYC + 1.
module dram_seq
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W   = 9,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 8,
    parameter int PIN_W   = 9,
    parameter int CNT_W   = 5,
    parameter int RCD_CYC = 2,
    parameter int KD_CYC  = 6,
    parameter int GAP_CYC = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ROW_W+COL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic                    ref_pending,
    input  logic [ROW_W-1:0]        ref_row,
    output logic                    ref_grant,
    input  logic [CNT_W-1:0]        phase,
    output logic                    phase_restart,
    output logic [PIN_W-1:0]        pin_a,
    output logic                    ras_n,
    output logic                    cas_n,
    output logic                    we_n,
    output logic                    oe_n,
    output logic [DATA_W-1:0]       dq_out,
    output logic                    dq_oe,
    input  logic [DATA_W-1:0]       dq_in,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam logic [CNT_W-1:0] GAP_OK_AT = CNT_W'(GAP_CYC - 2);
    localparam logic [CNT_W-1:0] CAS_AT    = CNT_W'(RCD_CYC - 1);
    localparam logic [CNT_W-1:0] END_AT    = CNT_W'(KD_CYC);

    seq_state_e       state;
    logic             is_ref;
    logic             is_wr;
    logic [COL_W-1:0] col_q;
    logic             gap_ok;
    logic             idle;

    // Launch conditions: idle and far enough from the last row fall
    always_comb begin
        idle          = (state == SEQ_IDLE);
        gap_ok        = (phase >= GAP_OK_AT);
        ref_grant     = idle && gap_ok && ref_pending;
        req_ready     = idle && gap_ok && !ref_pending;
        phase_restart = (state == SEQ_SETUP);
    end

    // Access state machine and registered pin drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            is_ref    <= 1'b0;
            is_wr     <= 1'b0;
            col_q     <= '0;
            pin_a     <= '0;
            ras_n     <= 1'b1;
            cas_n     <= 1'b1;
            we_n      <= 1'b1;
            oe_n      <= 1'b1;
            dq_out    <= '0;
            dq_oe     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (ref_grant) begin
                        is_ref <= 1'b1;
                        is_wr  <= 1'b0;
                        pin_a  <= PIN_W'(ref_row);
                        state  <= SEQ_SETUP;
                    end else if (req_valid && req_ready) begin
                        is_ref <= 1'b0;
                        is_wr  <= req_write;
                        col_q  <= req_addr[COL_W-1:0];
                        dq_out <= req_wdata;
                        pin_a  <= PIN_W'(req_addr[ADDR_W-1:COL_W]);
                        state  <= SEQ_SETUP;
                    end
                end
                SEQ_SETUP: begin
                    ras_n <= 1'b0;
                    state <= SEQ_ACTIVE;
                end
                SEQ_ACTIVE: begin
                    if (phase == '0 && !is_ref) begin
                        pin_a <= PIN_W'(col_q);
                        if (is_wr) begin
                            we_n  <= 1'b0;
                            dq_oe <= 1'b1;
                        end else begin
                            oe_n  <= 1'b0;
                        end
                    end
                    if (phase == CAS_AT && !is_ref) cas_n <= 1'b0;
                    if (phase == END_AT) begin
                        ras_n     <= 1'b1;
                        cas_n     <= 1'b1;
                        we_n      <= 1'b1;
                        oe_n      <= 1'b1;
                        dq_oe     <= 1'b0;
                        rsp_valid <= !is_ref;
                        if (!is_ref && !is_wr) rsp_rdata <= dq_in;
                        state     <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_ctrl.sv
// Controller for an asynchronous DRAM with multiplexed address pins.
// It converts nanosecond limits into cycle counts at CLK_NS and wires
// the phase counter, the refresh scheduler and the sequencer together.
// The data pins are exposed as out/enable/in for a pad-level tristate.
module dram_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int CLK_NS        = 10,
    parameter int ROW_W         = 9,
    parameter int COL_W         = 9,
    parameter int DATA_W        = 8,
    parameter int RC_NS         = 110,
    parameter int RAC_NS        = 60,
    parameter int CAC_NS        = 15,
    parameter int PC_NS         = 35,
    parameter int RCD_CYC       = 2,
    parameter int REF_WINDOW_NS = 8_000_000,
    localparam int ADDR_W       = ROW_W + COL_W,
    localparam int PIN_W        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [PIN_W-1:0]  dram_a,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int RC_CYC  = ns_to_cycles(RC_NS, CLK_NS);
    localparam int RAC_CYC = ns_to_cycles(RAC_NS, CLK_NS);
    localparam int CAC_CYC = ns_to_cycles(CAC_NS, CLK_NS);
    localparam int PC_CYC  = ns_to_cycles(PC_NS, CLK_NS);
    localparam int GAP_CYC = max2(max2(RC_CYC, PC_CYC), RCD_CYC + 4);
    localparam int KD_CYC  = max2(RAC_CYC, RCD_CYC + CAC_CYC);
    localparam int ROWS    = 1 << ROW_W;
    localparam int REF_INT = REF_WINDOW_NS / (CLK_NS * ROWS);
    localparam int CNT_W   = $clog2(GAP_CYC + KD_CYC + 2);

    logic [CNT_W-1:0] phase;
    logic             phase_restart;
    logic             ref_pending;
    logic             ref_grant;
    logic [ROW_W-1:0] ref_row;

    dram_phase_cnt #(.CNT_W(CNT_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_restart),
        .count   (phase)
    );

    dram_refresh_sched #(.ROW_W(ROW_W), .INTERVAL(REF_INT)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant   (ref_grant),
        .pending (ref_pending),
        .row     (ref_row)
    );

    dram_seq #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .DATA_W  (DATA_W),
        .PIN_W   (PIN_W),
        .CNT_W   (CNT_W),
        .RCD_CYC (RCD_CYC),
        .KD_CYC  (KD_CYC),
        .GAP_CYC (GAP_CYC)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .ref_pending   (ref_pending),
        .ref_row       (ref_row),
        .ref_grant     (ref_grant),
        .phase         (phase),
        .phase_restart (phase_restart),
        .pin_a         (dram_a),
        .ras_n         (dram_ras_n),
        .cas_n         (dram_cas_n),
        .we_n          (dram_we_n),
        .oe_n          (dram_oe_n),
        .dq_out        (dram_dq_out),
        .dq_oe         (dram_dq_oe),
        .dq_in         (dram_dq_in),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata)
    );
endmodule

// File: rtl/dram_ctrl_chk.sv
// Protocol checker for dram_ctrl, attached by bind below.
// It watches only the pins and the handshake, and it measures the
// row-strobe gap with its own counter.
module dram_ctrl_chk #(
    parameter int PIN_W   = 9,
    parameter int GAP_CYC = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PIN_W-1:0] dram_a,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic             dram_dq_oe,
    input logic             req_ready,
    input logic             rsp_valid
);
    logic        prev_ras;
    logic [15:0] since_fall;
    logic        ras_fell;

    // Row strobe falling-edge detect from the checker's own history
    always_comb ras_fell = prev_ras && !dram_ras_n;

    // Track cycles since the last row strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ras   <= 1'b1;
            since_fall <= 16'hFFFF;
        end else begin
            prev_ras <= dram_ras_n;
            if (ras_fell)                 since_fall <= 16'd1;
            else if (since_fall != 16'hFFFF) since_fall <= since_fall + 16'd1;
        end
    end

    // R6
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_we_n && !dram_oe_n));

    // R6
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && dram_oe_n));

    // R3
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R2
    row_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_a));

    // R4
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

    // R7
    row_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fell |-> (since_fall >= 16'(GAP_CYC)));

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> dram_ras_n);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind dram_ctrl dram_ctrl_chk #(.PIN_W(PIN_W), .GAP_CYC(GAP_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dram_a     (dram_a),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_oe_n  (dram_oe_n),
    .dram_dq_oe (dram_dq_oe),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid)
);

// File: tb/sim_dram_ctrl.sv
// Bench: a behavioural DRAM model checks the pin protocol on every
// falling clock edge. A response scoreboard predicts the cycle and
// value of every response from the requirements.
module sim_dram_ctrl;
    localparam int CLK_NS = 10;
    localparam int E_RC   = (110 + CLK_NS - 1) / CLK_NS;
    localparam int E_RAC  = (60 + CLK_NS - 1) / CLK_NS;
    localparam int E_CAC  = (15 + CLK_NS - 1) / CLK_NS;
    localparam int E_PC   = (35 + CLK_NS - 1) / CLK_NS;
    localparam int E_RCD  = 2;
    localparam int E_GAP  = (E_RC > E_PC) ? E_RC : E_PC;
    localparam int E_KD   = (E_RAC > E_RCD + E_CAC) ? E_RAC : (E_RCD + E_CAC);
    localparam int E_LAT  = E_KD + 3;
    localparam int E_REF  = 8_000_000 / (CLK_NS * 512);
    localparam int SLACK  = E_GAP + E_KD + 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [8:0]  dram_a;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [7:0]  dram_dq_out;
    logic        dram_dq_oe;
    logic [7:0]  dram_dq_in = 8'h00;

    dram_ctrl #(.CLK_NS(CLK_NS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural DRAM model ----------------
    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    int exp_addr_q[$];
    int due_q[$];
    bit rd_q[$];
    int dat_q[$];

    bit prev_ras = 1, prev_cas = 1, prev_we = 1;
    int since_ras = 100000, since_cas = 100000;
    int ras_age = 0, cas_age = 0;
    bit cas_seen = 0;
    int cur_row = 0, cur_col = 0, fall_cyc = 0;
    int exp_ref_row = 0, ref_count = 0, last_ref = -1;
    int min_gap = 100000;

    always @(negedge clk) begin
        if (rst_n) begin
            since_ras++;
            since_cas++;
            chk(!(!dram_we_n && !dram_oe_n), "R6", "we/oe both low", 0, 1);
            if (dram_dq_oe) chk(!dram_we_n && dram_oe_n, "R6", "bus driven outside write", dram_we_n, 0);
            if (!dram_ras_n) chk(!req_ready, "R10", "ready during row cycle", req_ready, 0);
            if (!dram_cas_n) chk(!dram_ras_n, "R3", "cas low without ras", dram_ras_n, 0);

            if (prev_ras && !dram_ras_n) begin
                chk(since_ras >= E_GAP, "R7", "row gap", since_ras, E_GAP);
                if (since_ras < min_gap) min_gap = since_ras;
                since_ras = 0;
                cur_row = int'(dram_a);
                ras_age = 0;
                cas_seen = 0;
                fall_cyc = cyc;
            end else if (!dram_ras_n) ras_age++;

            if (prev_cas && !dram_cas_n) begin
                chk(ras_age == E_RCD, "R3", "ras-to-cas cycles", ras_age, E_RCD);
                chk(since_cas >= E_PC, "R7", "column gap", since_cas, E_PC);
                since_cas = 0;
                cas_age = 0;
                cas_seen = 1;
                cur_col = int'(dram_a);
                if (exp_addr_q.size() > 0) begin
                    chk(exp_addr_q[0] == cur_row * 512 + cur_col, "R2", "row/col latched",
                        cur_row * 512 + cur_col, exp_addr_q[0]);
                    void'(exp_addr_q.pop_front());
                end else chk(0, "R2", "unexpected column access", cur_col, 0);
                if (!dram_we_n) begin
                    chk(!prev_we, "R4", "early write order", prev_we, 0);
                    chk(dram_dq_oe && dram_oe_n, "R4", "write drive", dram_dq_oe, 1);
                    mem[cur_row * 512 + cur_col] = dram_dq_out;
                end else begin
                    chk(!dram_oe_n && !dram_dq_oe, "R5", "read strobes", dram_oe_n, 0);
                end
            end else if (!dram_cas_n) cas_age++;

            if (!prev_ras && dram_ras_n && !cas_seen) begin
                chk(cur_row == exp_ref_row, "R9", "refresh row", cur_row, exp_ref_row);
                exp_ref_row = (exp_ref_row + 1) % 512;
                if (last_ref >= 0)
                    chk((fall_cyc - last_ref >= E_REF - SLACK) && (fall_cyc - last_ref <= E_REF + SLACK),
                        "R9", "refresh interval", fall_cyc - last_ref, E_REF);
                last_ref = fall_cyc;
                ref_count++;
            end

            if (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n &&
                ras_age >= E_RAC && cas_age >= E_CAC)
                dram_dq_in <= mem.exists(cur_row * 512 + cur_col) ? mem[cur_row * 512 + cur_col] : 8'h00;
            else
                dram_dq_in <= 8'hC3 ^ cyc[7:0];

            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_we  = dram_we_n;

            // response scoreboard (R8)
            if (rsp_valid) begin
                if (due_q.size() == 0) chk(0, "R8", "spurious response", cyc, 0);
                else begin
                    chk(due_q[0] == cyc, "R8", "response cycle", cyc, due_q[0]);
                    if (rd_q[0]) chk(int'(rsp_rdata) == dat_q[0], "R8", "read data", rsp_rdata, dat_q[0]);
                    void'(due_q.pop_front()); void'(rd_q.pop_front()); void'(dat_q.pop_front());
                end
            end else if (due_q.size() > 0 && due_q[0] < cyc) begin
                chk(0, "R8", "missing response", cyc, due_q[0]);
                void'(due_q.pop_front()); void'(rd_q.pop_front()); void'(dat_q.pop_front());
            end
        end
    end

    // Issue one request; called at a falling edge, returns at a falling edge
    task automatic issue(input bit wr, input int addr, input int data);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 18'(addr);
        req_wdata = 8'(data);
        while (!req_ready) @(negedge clk);
        if (wr) shadow[addr] = 8'(data);
        exp_addr_q.push_back(addr);
        due_q.push_back(cyc + E_LAT);
        rd_q.push_back(!wr);
        dat_q.push_back(shadow.exists(addr) ? int'(shadow[addr]) : 0);
        @(negedge clk);
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int base_refs;

    initial begin
        repeat (4) @(negedge clk);
        // R1 during reset
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes in reset", 0, 1);
        chk(!dram_dq_oe && !rsp_valid, "R1", "bus/rsp in reset", dram_dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 first cycle after reset
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes after reset", 0, 1);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);

        // R2 corner addresses, R4 writes, R5 reads
        issue(1, 0, 8'h3C);
        issue(1, 18'h3FFFF, 8'hA5);
        issue(1, 18'h001FF, 8'h0F);
        issue(1, 18'h3FE00, 8'hF0);
        issue(1, 18'h12345, 8'h77);
        go_idle();
        repeat (20) @(negedge clk);
        issue(0, 18'h3FE00, 0);
        issue(0, 0, 0);
        issue(0, 18'h001FF, 0);
        issue(0, 18'h3FFFF, 0);
        issue(0, 18'h12345, 0);
        go_idle();

        // R7/R11 back-to-back stream
        for (int i = 0; i < 48; i++) issue(1, (i * 40503 + 7) & 18'h3FFFF, (i * 37 + 1) & 8'hFF);
        for (int i = 0; i < 48; i++) issue(0, (i * 40503 + 7) & 18'h3FFFF, 0);
        go_idle();
        chk(min_gap == E_GAP, "R11", "streamed row gap", min_gap, E_GAP);

        // R10 refresh not starved by a continuous stream
        base_refs = ref_count;
        for (int i = 0; i < 420; i++) issue(i % 3 == 0, ((i * 977) % 48 * 40503 + 7) & 18'h3FFFF, (i * 11) & 8'hFF);
        go_idle();
        chk(ref_count - base_refs >= 2, "R10", "refreshes during stream", ref_count - base_refs, 2);

        // R9 refresh while idle
        base_refs = ref_count;
        repeat (3 * E_REF) @(negedge clk);
        chk(ref_count - base_refs >= 2, "R9", "refreshes while idle", ref_count - base_refs, 2);
        chk(ref_count >= cyc / E_REF - 1, "R9", "total refreshes", ref_count, cyc / E_REF - 1);

        repeat (E_LAT + 4) @(negedge clk);
        chk(due_q.size() == 0, "R8", "responses outstanding", due_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule